// File: doc/BRIEF.md
# Special-Purpose Register File with Indirect Banks

This block is a 128-word register file shared by two requesters: a compute core with a full 32-bit word port, and a narrow on-chip bus that moves one byte at a time. Words use a sign-and-mantissa layout. The sign sits in bit 31 and the mantissa in bits [22:0]. Addresses 10 to 127 are ordinary storage. Addresses 0 to 9 are special: at several of them a read returns status from a PWM unit, while a write at the same address stores a command for that unit. The PWM unit and the arithmetic core are outside the block. They appear only as plain status inputs and configuration outputs.

Two further banks of 32 words each sit behind two window addresses. A 5-bit index selects the entry, and that index is written through a mantissa field of one of the special addresses. One register bit drives the reset of the compute core. When both ports write in the same cycle, the core has priority. The bus port then sees a wait, keeps its request in place, and completes on a later cycle.

Top module: `spRegFile`

## Requirements
- R1: After reset every register, bank entry and byte-staging register is zero, `coreResetN` is low and the ready flag is clear.
- R2: A `pwmCycleStart` pulse sets the ready flag, which reads back in bit 31 of address 0. A core read of address 0 clears it at the next edge. When a pulse and such a read fall in the same cycle, the flag stays set.
- R3: Writes to addresses 0, 1 and 2 drive `dutyU`, `dutyV` and `dutyW` from data bits [14:0]. Reads of address 0 return only the ready flag. Reads of addresses 1 and 2 return `phaseCurU` and `phaseCurV` zero-extended from bit 0.
- R4: A write to address 3 sets `deadTime` from bits [8:0], and a write to address 4 sets `acqTime` from bits [14:0]. Reads return `dcVolt` (bits [11:0]) at address 3 and `dcVoltRecip` (bits [22:0]) at address 4, with all other bits zero.
- R5: Address 5 is a read/write offset held in bits [13:0]. It drives `curOffset`, and its other bits read as zero.
- R6: A read of address 6 returns `noCurrent` in bit 31 with all other bits zero. A write to address 6 loads the bank index from data bits [22:18].
- R7: Address 7 bit 0 is the core enable. `coreResetN` equals that bit, a zero holds the core in reset, and a read returns the bit in position 0 with all other bits zero.
- R8: Address 8 reads and writes entry [index] of bank A, and address 9 reads and writes entry [index] of bank B. The two banks are independent.
- R9: Addresses 10 to 127 store and return full 32-bit words.
- R10: On the bus port, `busRdData` shows byte `busByteSel` (bits [8*sel+7:8*sel]) of the addressed read word. Bus writes with byte select 0, 1 or 2 are only staged. A write with byte select 3 commits the staged bytes as bits [23:0] and the bus byte as bits [31:24].
- R11: When a core write and a bus commit (byte select 3) occur in the same cycle, only the core write takes effect and `busWait` is high. A commit without a competing core write completes with `busWait` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreWrEn | input | 1 | Core write request |
| coreRdEn | input | 1 | Core read request |
| coreAddr | input | 7 | Core word address |
| coreWrData | input | 32 | Core write word |
| coreRdData | output | 32 | Core read word for coreAddr |
| busWrEn | input | 1 | Bus byte write request |
| busAddr | input | 7 | Bus word address |
| busByteSel | input | 2 | Byte lane within the word |
| busWrData | input | 8 | Bus write byte |
| busRdData | output | 8 | Selected byte of the bus read word |
| busWait | output | 1 | Bus commit blocked this cycle, retry |
| pwmCycleStart | input | 1 | One-cycle pulse at each PWM period start |
| phaseCurU | input | 15 | U-phase current status |
| phaseCurV | input | 15 | V-phase current status |
| dcVolt | input | 12 | Bus voltage status |
| dcVoltRecip | input | 23 | Reciprocal bus voltage status |
| noCurrent | input | 1 | Current sample missing flag |
| dutyU | output | 15 | U-phase duty command |
| dutyV | output | 15 | V-phase duty command |
| dutyW | output | 15 | W-phase duty command |
| deadTime | output | 9 | Dead time in clock cycles |
| acqTime | output | 15 | Minimum acquisition time in clock cycles |
| curOffset | output | 14 | Zero-current offset |
| coreResetN | output | 1 | Core reset, low while enable bit is zero |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any request and that `pwmCycleStart` is a single-cycle pulse. They also assume that the bus keeps a blocked commit steady until `busWait` drops. The stimulus follows all three rules. Every request comes from tasks that drive one operation per cycle at the falling edge. The pulse task raises `pwmCycleStart` for exactly one cycle. A conflict is always followed by a retry cycle with the same bus address and byte, before any other bus activity.

// File: rtl/spRegPkg.sv
package spRegPkg;
  localparam int unsigned WordW = 32;
  localparam int unsigned AddrW = 7;
  localparam int unsigned ByteW = 8;
  localparam int unsigned BytesPerWord = WordW / ByteW;
  localparam int unsigned ByteSelW = $clog2(BytesPerWord);
  localparam int unsigned MantW = 23;

  localparam int unsigned DutyW  = 15;
  localparam int unsigned DeadW  = 9;
  localparam int unsigned AcqW   = 15;
  localparam int unsigned OffW   = 14;
  localparam int unsigned CurW   = 15;
  localparam int unsigned VoltW  = 12;
  localparam int unsigned RecipW = 23;

  localparam logic [AddrW-1:0] AdrCmdU   = 7'd0;
  localparam logic [AddrW-1:0] AdrCmdV   = 7'd1;
  localparam logic [AddrW-1:0] AdrCmdW   = 7'd2;
  localparam logic [AddrW-1:0] AdrTiming = 7'd3;
  localparam logic [AddrW-1:0] AdrAcq    = 7'd4;
  localparam logic [AddrW-1:0] AdrOffset = 7'd5;
  localparam logic [AddrW-1:0] AdrIndex  = 7'd6;
  localparam logic [AddrW-1:0] AdrEnable = 7'd7;
  localparam logic [AddrW-1:0] AdrWinA   = 7'd8;
  localparam logic [AddrW-1:0] AdrWinB   = 7'd9;

  typedef struct packed {
    logic             wrEn;
    logic [AddrW-1:0] wrAddr;
    logic [WordW-1:0] wrData;
    logic             clrReady;
  } regStrobeT;
endpackage

// File: rtl/spRegCtrl.sv
module spRegCtrl
  import spRegPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreWrEn,
  input  logic                coreRdEn,
  input  logic [AddrW-1:0]    coreAddr,
  input  logic [WordW-1:0]    coreWrData,
  input  logic                busWrEn,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [ByteSelW-1:0] busByteSel,
  input  logic [ByteW-1:0]    busWrData,
  output regStrobeT           strobe,
  output logic                busWait
);
  localparam int unsigned LastByte = BytesPerWord - 1;

  logic [LastByte*ByteW-1:0] stageQ;
  logic busCommit;

  for (genvar b = 0; b < LastByte; b++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[b*ByteW +: ByteW] <= '0;
      end else if (busWrEn && busByteSel == ByteSelW'(b)) begin
        stageQ[b*ByteW +: ByteW] <= busWrData;
      end
    end
  end

  always_comb begin
    busCommit = busWrEn && (busByteSel == ByteSelW'(LastByte));
    busWait = busCommit && coreWrEn;
    strobe.wrEn = coreWrEn || busCommit;
    strobe.wrAddr = coreWrEn ? coreAddr : busAddr;
    strobe.wrData = coreWrEn ? coreWrData : {busWrData, stageQ};
    strobe.clrReady = coreRdEn && (coreAddr == AdrCmdU);
  end
endmodule

// File: rtl/spRegData.sv
module spRegData
  import spRegPkg::*;
#(
  parameter int unsigned NumRegs   = 128,
  parameter int unsigned BankDepth = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobeT                  strobe,
  input  logic                       pwmCycleStart,
  input  logic [CurW-1:0]            phaseCurU,
  input  logic [CurW-1:0]            phaseCurV,
  input  logic [VoltW-1:0]           dcVolt,
  input  logic [RecipW-1:0]          dcVoltRecip,
  input  logic                       noCurrent,
  input  logic [AddrW-1:0]           coreAddr,
  input  logic [AddrW-1:0]           busAddr,
  output logic [WordW-1:0]           coreWord,
  output logic [WordW-1:0]           busWord,
  output logic [DutyW-1:0]           dutyU,
  output logic [DutyW-1:0]           dutyV,
  output logic [DutyW-1:0]           dutyW,
  output logic [DeadW-1:0]           deadTime,
  output logic [AcqW-1:0]            acqTime,
  output logic [OffW-1:0]            curOffset,
  output logic                       enableQ,
  output logic                       readyQ,
  output logic [$clog2(BankDepth)-1:0] indexQ
);
  localparam int unsigned IdxW = $clog2(BankDepth);
  localparam int unsigned IdxLsb = MantW - IdxW;

  logic [WordW-1:0] plainMem [NumRegs];
  logic [WordW-1:0] bankA [BankDepth];
  logic [WordW-1:0] bankB [BankDepth];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyU <= '0; dutyV <= '0; dutyW <= '0;
      deadTime <= '0; acqTime <= '0; curOffset <= '0;
      enableQ <= 1'b0; readyQ <= 1'b0; indexQ <= '0;
      for (int i = 0; i < NumRegs; i++) plainMem[i] <= '0;
      for (int i = 0; i < BankDepth; i++) begin
        bankA[i] <= '0;
        bankB[i] <= '0;
      end
    end else begin
      if (strobe.wrEn) begin
        case (strobe.wrAddr)
          AdrCmdU:   dutyU <= strobe.wrData[DutyW-1:0];
          AdrCmdV:   dutyV <= strobe.wrData[DutyW-1:0];
          AdrCmdW:   dutyW <= strobe.wrData[DutyW-1:0];
          AdrTiming: deadTime <= strobe.wrData[DeadW-1:0];
          AdrAcq:    acqTime <= strobe.wrData[AcqW-1:0];
          AdrOffset: curOffset <= strobe.wrData[OffW-1:0];
          AdrIndex:  indexQ <= strobe.wrData[IdxLsb +: IdxW];
          AdrEnable: enableQ <= strobe.wrData[0];
          AdrWinA:   bankA[indexQ] <= strobe.wrData;
          AdrWinB:   bankB[indexQ] <= strobe.wrData;
          default:   plainMem[strobe.wrAddr] <= strobe.wrData;
        endcase
      end
      if (pwmCycleStart) readyQ <= 1'b1;
      else if (strobe.clrReady) readyQ <= 1'b0;
    end
  end

  function automatic logic [WordW-1:0] readWord(input logic [AddrW-1:0] a);
    case (a)
      AdrCmdU:   return {readyQ, {(WordW-1){1'b0}}};
      AdrCmdV:   return WordW'(phaseCurU);
      AdrCmdW:   return WordW'(phaseCurV);
      AdrTiming: return WordW'(dcVolt);
      AdrAcq:    return WordW'(dcVoltRecip);
      AdrOffset: return WordW'(curOffset);
      AdrIndex:  return {noCurrent, {(WordW-1){1'b0}}};
      AdrEnable: return WordW'(enableQ);
      AdrWinA:   return bankA[indexQ];
      AdrWinB:   return bankB[indexQ];
      default:   return plainMem[a];
    endcase
  endfunction

  always_comb begin
    coreWord = readWord(coreAddr);
    busWord = readWord(busAddr);
  end
endmodule

// File: rtl/spRegFile.sv
module spRegFile
  import spRegPkg::*;
#(
  parameter int unsigned NumRegs   = 128,
  parameter int unsigned BankDepth = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreWrEn,
  input  logic                coreRdEn,
  input  logic [AddrW-1:0]    coreAddr,
  input  logic [WordW-1:0]    coreWrData,
  output logic [WordW-1:0]    coreRdData,
  input  logic                busWrEn,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [ByteSelW-1:0] busByteSel,
  input  logic [ByteW-1:0]    busWrData,
  output logic [ByteW-1:0]    busRdData,
  output logic                busWait,
  input  logic                pwmCycleStart,
  input  logic [CurW-1:0]     phaseCurU,
  input  logic [CurW-1:0]     phaseCurV,
  input  logic [VoltW-1:0]    dcVolt,
  input  logic [RecipW-1:0]   dcVoltRecip,
  input  logic                noCurrent,
  output logic [DutyW-1:0]    dutyU,
  output logic [DutyW-1:0]    dutyV,
  output logic [DutyW-1:0]    dutyW,
  output logic [DeadW-1:0]    deadTime,
  output logic [AcqW-1:0]     acqTime,
  output logic [OffW-1:0]     curOffset,
  output logic                coreResetN
);
  localparam int unsigned IdxW = $clog2(BankDepth);

  regStrobeT strobe;
  logic [WordW-1:0] busWord;
  logic enableQ;
  logic readyQ;
  logic [IdxW-1:0] indexQ;

  spRegCtrl u_ctrl (
    .clk, .rstN, .coreWrEn, .coreRdEn, .coreAddr, .coreWrData,
    .busWrEn, .busAddr, .busByteSel, .busWrData,
    .strobe, .busWait
  );

  spRegData #(.NumRegs(NumRegs), .BankDepth(BankDepth)) u_data (
    .clk, .rstN, .strobe, .pwmCycleStart, .phaseCurU, .phaseCurV,
    .dcVolt, .dcVoltRecip, .noCurrent, .coreAddr, .busAddr,
    .coreWord(coreRdData), .busWord, .dutyU, .dutyV, .dutyW,
    .deadTime, .acqTime, .curOffset, .enableQ, .readyQ, .indexQ
  );

  assign busRdData = busWord[busByteSel*ByteW +: ByteW];
  assign coreResetN = enableQ;
endmodule

// File: rtl/spRegChecker.sv
module spRegChecker
  import spRegPkg::*;
#(
  parameter int unsigned IdxW = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                coreWrEn,
  input logic                coreRdEn,
  input logic [AddrW-1:0]    coreAddr,
  input logic [WordW-1:0]    coreWrData,
  input logic                busWrEn,
  input logic [ByteSelW-1:0] busByteSel,
  input logic                busWait,
  input logic                pwmCycleStart,
  input logic [DutyW-1:0]    dutyU,
  input logic [OffW-1:0]     curOffset,
  input logic                coreResetN,
  input logic                readyQ,
  input logic [IdxW-1:0]     indexQ
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (!coreResetN && !readyQ && dutyU == '0 && curOffset == '0));

  assert_ready_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    pwmCycleStart |=> readyQ);

  assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdEn && coreAddr == AdrCmdU && !pwmCycleStart) |=> !readyQ);

  assert_duty_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && coreAddr == AdrCmdU) |=> dutyU == $past(coreWrData[DutyW-1:0]));

  assert_index_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && coreAddr == AdrIndex) |=> indexQ == $past(coreWrData[MantW-IdxW +: IdxW]));

  assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && coreAddr == AdrEnable) |=> coreResetN == $past(coreWrData[0]));

  assert_core_priority_R11: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && coreAddr == AdrOffset && busWrEn) |=> curOffset == $past(coreWrData[OffW-1:0]));

  assert_no_wait_alone_R11: assert property (@(posedge clk) disable iff (!rstN)
    !coreWrEn |-> !busWait);

  assert_wait_on_commit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && busWrEn && busByteSel == ByteSelW'(BytesPerWord-1)) |-> busWait);
endmodule

bind spRegFile spRegChecker #(.IdxW(IdxW)) u_checker (
  .clk(clk), .rstN(rstN), .coreWrEn(coreWrEn), .coreRdEn(coreRdEn),
  .coreAddr(coreAddr), .coreWrData(coreWrData), .busWrEn(busWrEn),
  .busByteSel(busByteSel), .busWait(busWait), .pwmCycleStart(pwmCycleStart),
  .dutyU(dutyU), .curOffset(curOffset), .coreResetN(coreResetN),
  .readyQ(readyQ), .indexQ(indexQ)
);

// File: tb/test_spRegFile.sv
module test_spRegFile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreWrEn = 0, coreRdEn = 0;
  logic [6:0] coreAddr = '0;
  logic [31:0] coreWrData = '0;
  logic [31:0] coreRdData;
  logic busWrEn = 0;
  logic [6:0] busAddr = '0;
  logic [1:0] busByteSel = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic busWait;
  logic pwmCycleStart = 0;
  logic [14:0] phaseCurU = '0, phaseCurV = '0;
  logic [11:0] dcVolt = '0;
  logic [22:0] dcVoltRecip = '0;
  logic noCurrent = 0;
  logic [14:0] dutyU, dutyV, dutyW;
  logic [8:0] deadTime;
  logic [14:0] acqTime;
  logic [13:0] curOffset;
  logic coreResetN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic [14:0] mDuty [3];
  logic [8:0] mDead;
  logic [14:0] mAcq;
  logic [13:0] mOff;
  logic [4:0] mIdx;
  logic mEn, mReady;
  logic [31:0] mBankA [32];
  logic [31:0] mBankB [32];
  logic [31:0] mPlain [128];
  logic [23:0] mStage;

  spRegFile i_spRegFile (.*);

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] a);
    case (a)
      7'd0: return {mReady, 31'b0};
      7'd1: return {17'b0, phaseCurU};
      7'd2: return {17'b0, phaseCurV};
      7'd3: return {20'b0, dcVolt};
      7'd4: return {9'b0, dcVoltRecip};
      7'd5: return {18'b0, mOff};
      7'd6: return {noCurrent, 31'b0};
      7'd7: return {31'b0, mEn};
      7'd8: return mBankA[mIdx];
      7'd9: return mBankB[mIdx];
      default: return mPlain[a];
    endcase
  endfunction

  function automatic void modelWrite(input logic [6:0] a, input logic [31:0] d);
    case (a)
      7'd0: mDuty[0] = d[14:0];
      7'd1: mDuty[1] = d[14:0];
      7'd2: mDuty[2] = d[14:0];
      7'd3: mDead = d[8:0];
      7'd4: mAcq = d[14:0];
      7'd5: mOff = d[13:0];
      7'd6: mIdx = d[22:18];
      7'd7: mEn = d[0];
      7'd8: mBankA[mIdx] = d;
      7'd9: mBankB[mIdx] = d;
      default: mPlain[a] = d;
    endcase
  endfunction

  function automatic string tagOf(input logic [6:0] a);
    if (a <= 7'd2) return "R3";
    if (a <= 7'd4) return "R4";
    if (a == 7'd5) return "R5";
    if (a == 7'd6) return "R6";
    if (a == 7'd7) return "R7";
    if (a <= 7'd9) return "R8";
    return "R9";
  endfunction

  task automatic idle();
    coreWrEn = 0; coreRdEn = 0; busWrEn = 0; pwmCycleStart = 0;
  endtask

  task automatic coreWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    coreWrEn = 1; coreAddr = a; coreWrData = d;
    @(posedge clk);
    modelWrite(a, d);
    #1 idle();
  endtask

  task automatic coreRd(input logic [6:0] a);
    @(negedge clk);
    coreRdEn = 1; coreAddr = a;
    #1 chk(coreRdData, expRead(a), (a == 7'd0 || a == 7'd6) ? ((a == 7'd0) ? "R2" : "R6") : tagOf(a));
    @(posedge clk);
    if (a == 7'd0) mReady = 1'b0;
    #1 idle();
  endtask

  task automatic pwmPulse();
    @(negedge clk);
    pwmCycleStart = 1;
    @(posedge clk);
    mReady = 1'b1;
    #1 idle();
  endtask

  task automatic busWrByte(input logic [6:0] a, input logic [1:0] s, input logic [7:0] b);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busByteSel = s; busWrData = b;
    #1 chk({31'b0, busWait}, 32'd0, "R11 no wait");
    @(posedge clk);
    if (s == 2'd3) modelWrite(a, {b, mStage});
    else mStage[s*8 +: 8] = b;
    #1 idle();
  endtask

  task automatic busWrWord(input logic [6:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) busWrByte(a, 2'(b), d[b*8 +: 8]);
  endtask

  task automatic busRd(input logic [6:0] a, input logic [1:0] s);
    logic [31:0] w;
    @(negedge clk);
    busAddr = a; busByteSel = s;
    #1 w = expRead(a);
    chk({24'b0, busRdData}, {24'b0, w[s*8 +: 8]}, "R10 bus read");
  endtask

  task automatic checkOuts();
    @(negedge clk);
    #1;
    chk({17'b0, dutyU}, {17'b0, mDuty[0]}, "R3 dutyU");
    chk({17'b0, dutyV}, {17'b0, mDuty[1]}, "R3 dutyV");
    chk({17'b0, dutyW}, {17'b0, mDuty[2]}, "R3 dutyW");
    chk({23'b0, deadTime}, {23'b0, mDead}, "R4 deadTime");
    chk({17'b0, acqTime}, {17'b0, mAcq}, "R4 acqTime");
    chk({18'b0, curOffset}, {18'b0, mOff}, "R5 curOffset");
    chk({31'b0, coreResetN}, {31'b0, mEn}, "R7 coreResetN");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) mDuty[i] = '0;
    mDead = '0; mAcq = '0; mOff = '0; mIdx = '0; mEn = 0; mReady = 0; mStage = '0;
    for (int i = 0; i < 32; i++) begin mBankA[i] = '0; mBankB[i] = '0; end
    for (int i = 0; i < 128; i++) mPlain[i] = '0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkOuts();
    coreRd(7'd0);
    coreRd(7'd20);
    coreRd(7'd8);
    busRd(7'd127, 2'd3);

    // R2 ready set, clear, and set-wins
    pwmPulse();
    coreRd(7'd0);
    coreRd(7'd0);
    @(negedge clk);
    pwmCycleStart = 1; coreRdEn = 1; coreAddr = 7'd0;
    @(posedge clk);
    mReady = 1'b1;
    #1 idle();
    coreRd(7'd0);

    // R7 enable bit, only bit 0 matters
    coreWr(7'd7, 32'hFFFF_FFFE);
    checkOuts();
    coreWr(7'd7, 32'h0000_0001);
    checkOuts();
    coreRd(7'd7);

    // R6 index from bits [22:18]; R8 windows
    coreWr(7'd6, 32'h007C_0000);
    coreWr(7'd8, 32'hA5A5_0031);
    coreWr(7'd9, 32'h5A5A_0931);
    coreWr(7'd6, 32'hFF83_FFFF);
    coreRd(7'd8);
    coreRd(7'd9);
    coreWr(7'd6, 32'h007C_0000);
    coreRd(7'd8);
    coreRd(7'd9);
    noCurrent = 1;
    coreRd(7'd6);

    // R4/R5 masking
    coreWr(7'd3, 32'hFFFF_FFFF);
    coreWr(7'd4, 32'hFFFF_FFFF);
    coreWr(7'd5, 32'hFFFF_FFFF);
    checkOuts();
    coreRd(7'd5);

    // R10 bus staging then commit
    busWrByte(7'd33, 2'd0, 8'h11);
    busWrByte(7'd33, 2'd1, 8'h22);
    coreRd(7'd33);
    busWrByte(7'd33, 2'd2, 8'h33);
    busWrByte(7'd33, 2'd3, 8'h44);
    coreRd(7'd33);
    for (int s = 0; s < 4; s++) busRd(7'd33, 2'(s));

    // R11 conflict: core wins, bus retries
    busWrByte(7'd50, 2'd0, 8'hDE);
    busWrByte(7'd50, 2'd1, 8'hAD);
    busWrByte(7'd50, 2'd2, 8'hBE);
    @(negedge clk);
    coreWrEn = 1; coreAddr = 7'd50; coreWrData = 32'h1234_5678;
    busWrEn = 1; busAddr = 7'd50; busByteSel = 2'd3; busWrData = 8'hEF;
    #1 chk({31'b0, busWait}, 32'd1, "R11 wait on conflict");
    @(posedge clk);
    modelWrite(7'd50, 32'h1234_5678);
    #1 coreWrEn = 0;
    coreAddr = 7'd50;
    #1 chk(coreRdData, 32'h1234_5678, "R11 core value wins");
    chk({31'b0, busWait}, 32'd0, "R11 retry no wait");
    @(posedge clk);
    modelWrite(7'd50, {8'hEF, mStage});
    #1 idle();
    coreRd(7'd50);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [6:0] a;
      logic [31:0] d;
      op = int'($urandom_range(0, 6));
      a = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 3) == 0) a = 7'($urandom_range(0, 9));
      d = $urandom;
      if ($urandom_range(0, 7) == 0) begin
        phaseCurU = 15'($urandom); phaseCurV = 15'($urandom);
        dcVolt = 12'($urandom); dcVoltRecip = 23'($urandom);
        noCurrent = 1'($urandom);
      end
      case (op)
        0, 1: coreWr(a, d);
        2, 3: coreRd(a);
        4: busWrWord(a, d);
        5: busRd(a, 2'($urandom_range(0, 3)));
        default: pwmPulse();
      endcase
      if (n % 50 == 0) checkOuts();
    end
    checkOuts();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule